// File: doc/BRIEF.md
# External Interrupt Pin Conditioner

This block sits between a set of external interrupt pins and the chip's interrupt controller. Every live pin passes through a synchronizer. Software then chooses, for each pin, one of four sensing modes: low level, rising edge, falling edge or either edge. In the three edge modes a detected edge sets a sticky flag. Software acknowledges that flag by writing a one to its bit. A request toward the controller is raised only while the pin is enabled and is configured as an input.

Each pin can also serve as a plain output. A direction bit drives the pad's output enable, and a data latch supplies the output value. The lowest pin position is reserved: every register bit that belongs to it reads zero, and it never raises a request. Configuration uses a simple single-cycle write strobe with a combinational read path.

Top module: `ep_irq_cond`

## Requirements
- R1: Register offsets on `reg_addr` are 0 = sense modes, 1 = direction, 2 = interrupt enable, 3 = data, 4 = flags; a write takes effect at the clock edge where `reg_wr` is high; after reset every mode field, direction bit and enable bit is 0, every flag is 0 and `irq_req` and `pin_oe` are all 0.
- R2: Pin position 0 is reserved: its bit reads 0 in every register, `irq_req[0]`, `pin_oe[0]` and `pin_out[0]` stay 0, and writes to its bits have no effect.
- R3: The sense-mode register holds a 2-bit field for pin n at bits 2n+1:2n and reads back what was written; 00 = low level, 01 = rising edge, 10 = falling edge, 11 = either edge.
- R4: In low-level mode the pin's flag reads 1 exactly while the synchronized pin is low, and reads 0 while it is high.
- R5: In an edge mode, only an edge of the selected polarity sets the flag. The flag then stays set while the pin keeps changing.
- R6: Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged.
- R7: When an edge is detected in the same cycle as a write of 1 to the same flag bit, the flag ends the cycle set.
- R8: `irq_req[n]` is high only when flag n is set, enable bit n is 1 and direction bit n is 0 (input).
- R9: Direction bit n = 1 drives `pin_oe[n]` high and puts data-latch bit n on `pin_out[n]`; a data read returns the latch bit for output pins and the synchronized pin value for input pins.
- R10: A pin change is seen on the flag and on `irq_req` after the third rising clock edge following the change, never earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 3 | Register offset for reads and writes |
| reg_wr | input | 1 | Write strobe, one write per cycle high |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| pin_in | input | 8 | External pin levels, asynchronous |
| pin_out | output | 8 | Output value per pin |
| pin_oe | output | 8 | Output enable per pin |
| irq_req | output | 8 | Request per pin toward the interrupt controller |

## Verification
Two events can hit the same flag bit in one cycle: a freshly detected edge and a software write of one that acknowledges it. The bench sets a flag with a rising edge, drives the pin low, and then drives it high again. It times a clear write so that the strobe lands on the exact edge where the synchronized rise is registered. The flag must read set afterwards, and a later plain clear must empty it. Both results are judged at the ports, through the flag read and `irq_req`.

// File: rtl/ep_irq_pkg.sv
package ep_irq_pkg;

   typedef enum logic [1:0] {
      SENSE_LOW  = 2'b00,
      SENSE_RISE = 2'b01,
      SENSE_FALL = 2'b10,
      SENSE_ANY  = 2'b11
   } sense_e;

   localparam int ADDR_W = 3;

   localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
   localparam logic [ADDR_W-1:0] A_DIR  = 3'd1;
   localparam logic [ADDR_W-1:0] A_ENA  = 3'd2;
   localparam logic [ADDR_W-1:0] A_DATA = 3'd3;
   localparam logic [ADDR_W-1:0] A_FLAG = 3'd4;

endpackage

// File: rtl/ep_sync.sv
module ep_sync #(
   parameter int   W       = 8,
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("ep_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stg[k] <= {W{RST_VAL}};
      end else begin
         stg[0] <= d;
         for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/ep_pin_cell.sv
module ep_pin_cell
   import ep_irq_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  sense_e mode,
   input  logic   smp,
   input  logic   clr,
   output logic   flag,
   output logic   edge_hit
);

   logic prev_q;
   logic flag_q;
   logic rise;
   logic fall;

   assign rise = smp & ~prev_q;
   assign fall = ~smp & prev_q;

   always_comb begin
      case (mode)
         SENSE_RISE: edge_hit = rise;
         SENSE_FALL: edge_hit = fall;
         SENSE_ANY:  edge_hit = rise | fall;
         default:    edge_hit = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b1;
         flag_q <= 1'b0;
      end else begin
         prev_q <= smp;
         if (mode == SENSE_LOW)
            flag_q <= ~smp;
         else if (edge_hit)
            flag_q <= 1'b1;
         else if (clr)
            flag_q <= 1'b0;
      end
   end

   assign flag = flag_q;

endmodule

// File: rtl/ep_irq_cond.sv
module ep_irq_cond
   import ep_irq_pkg::*;
#(
   parameter int NPINS       = 8,
   parameter int FIRST_PIN   = 1,
   parameter int SYNC_STAGES = 2,
   parameter int DW          = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [DW-1:0]     reg_wdata,
   output logic [DW-1:0]     reg_rdata,
   input  logic [NPINS-1:0]  pin_in,
   output logic [NPINS-1:0]  pin_out,
   output logic [NPINS-1:0]  pin_oe,
   output logic [NPINS-1:0]  irq_req
);

   localparam int MW = 2 * NPINS;

   if (DW < MW) begin : g_bad_dw
      $error("ep_irq_cond: DW must hold two bits per pin");
   end
   if (FIRST_PIN >= NPINS) begin : g_bad_first
      $error("ep_irq_cond: FIRST_PIN must leave at least one live pin");
   end

   logic [MW-1:0]    mode_q;
   logic [NPINS-1:0] dir_q;
   logic [NPINS-1:0] ena_q;
   logic [NPINS-1:0] dout_q;
   logic [NPINS-1:0] flag_q;
   logic [NPINS-1:0] syn_q;
   logic [NPINS-1:0] edge_hit;
   logic [NPINS-1:0] din_view;

   logic wr_mode, wr_dir, wr_ena, wr_data, wr_flag;

   assign wr_mode = reg_wr && (reg_addr == A_MODE);
   assign wr_dir  = reg_wr && (reg_addr == A_DIR);
   assign wr_ena  = reg_wr && (reg_addr == A_ENA);
   assign wr_data = reg_wr && (reg_addr == A_DATA);
   assign wr_flag = reg_wr && (reg_addr == A_FLAG);

   ep_sync #(
      .W      (NPINS),
      .STAGES (SYNC_STAGES),
      .RST_VAL(1'b1)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pin_in),
      .q    (syn_q)
   );

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      if (i >= FIRST_PIN) begin : g_live
         sense_e mode_r;
         logic   dir_r;
         logic   ena_r;
         logic   dout_r;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mode_r <= SENSE_LOW;
               dir_r  <= 1'b0;
               ena_r  <= 1'b0;
               dout_r <= 1'b0;
            end else begin
               if (wr_mode) mode_r <= sense_e'(reg_wdata[2*i +: 2]);
               if (wr_dir)  dir_r  <= reg_wdata[i];
               if (wr_ena)  ena_r  <= reg_wdata[i];
               if (wr_data) dout_r <= reg_wdata[i];
            end
         end

         ep_pin_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .mode    (mode_r),
            .smp     (syn_q[i]),
            .clr     (wr_flag & reg_wdata[i]),
            .flag    (flag_q[i]),
            .edge_hit(edge_hit[i])
         );

         assign mode_q[2*i +: 2] = mode_r;
         assign dir_q[i]         = dir_r;
         assign ena_q[i]         = ena_r;
         assign dout_q[i]        = dout_r;
         assign din_view[i]      = dir_r ? dout_r : syn_q[i];
         assign irq_req[i]       = flag_q[i] & ena_r & ~dir_r;
         assign pin_out[i]       = dout_r;
         assign pin_oe[i]        = dir_r;
      end else begin : g_rsv
         assign mode_q[2*i +: 2] = 2'b00;
         assign dir_q[i]         = 1'b0;
         assign ena_q[i]         = 1'b0;
         assign dout_q[i]        = 1'b0;
         assign flag_q[i]        = 1'b0;
         assign edge_hit[i]      = 1'b0;
         assign din_view[i]      = 1'b0;
         assign irq_req[i]       = 1'b0;
         assign pin_out[i]       = 1'b0;
         assign pin_oe[i]        = 1'b0;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_MODE:  reg_rdata[MW-1:0]    = mode_q;
         A_DIR:   reg_rdata[NPINS-1:0] = dir_q;
         A_ENA:   reg_rdata[NPINS-1:0] = ena_q;
         A_DATA:  reg_rdata[NPINS-1:0] = din_view;
         A_FLAG:  reg_rdata[NPINS-1:0] = flag_q;
         default: reg_rdata            = '0;
      endcase
   end

   logic unused_bits;
   assign unused_bits = ^{reg_wdata, syn_q, dout_q, edge_hit};

endmodule

// File: rtl/ep_irq_chk.sv
module ep_irq_chk #(
   parameter int NPINS     = 8,
   parameter int FIRST_PIN = 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               reg_wr,
   input logic [2*NPINS-1:0] mode_q,
   input logic [NPINS-1:0]   flag_q,
   input logic [NPINS-1:0]   syn_q,
   input logic [NPINS-1:0]   edge_hit,
   input logic [NPINS-1:0]   ena_q,
   input logic [NPINS-1:0]   pin_oe,
   input logic [NPINS-1:0]   irq_req
);

   localparam logic [NPINS-1:0] LIVE = {NPINS{1'b1}} << FIRST_PIN;

   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req & ~(ena_q & ~pin_oe)) == '0);  // R8

   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req & ~flag_q) == '0);  // R8

   AST_RSV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_req | pin_oe | flag_q) & ~LIVE) == '0);  // R2

   for (genvar i = FIRST_PIN; i < NPINS; i++) begin : g_bit
      AST_LVL_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_q[2*i +: 2] == 2'b00) |=> (flag_q[i] == !$past(syn_q[i])));  // R4

      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         ((mode_q[2*i +: 2] != 2'b00) && flag_q[i] && !reg_wr) |=> flag_q[i]);  // R5

      AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         edge_hit[i] |=> flag_q[i]);  // R7
   end

endmodule

bind ep_irq_cond ep_irq_chk #(
   .NPINS    (NPINS),
   .FIRST_PIN(FIRST_PIN)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .reg_wr  (reg_wr),
   .mode_q  (mode_q),
   .flag_q  (flag_q),
   .syn_q   (syn_q),
   .edge_hit(edge_hit),
   .ena_q   (ena_q),
   .pin_oe  (pin_oe),
   .irq_req (irq_req)
);

// File: tb/ep_irq_cond_test.sv
module ep_irq_cond_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  reg_addr = 3'd0;
   logic        reg_wr = 1'b0;
   logic [15:0] reg_wdata = 16'h0;
   logic [15:0] reg_rdata;
   logic [7:0]  pin_in = 8'hFF;
   logic [7:0]  pin_out;
   logic [7:0]  pin_oe;
   logic [7:0]  irq_req;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   ep_irq_cond uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_addr (reg_addr),
      .reg_wr   (reg_wr),
      .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .pin_in   (pin_in),
      .pin_out  (pin_out),
      .pin_oe   (pin_oe),
      .irq_req  (irq_req)
   );

   // vector fields: addr[43:41] wr[40] wdata[39:24] pins[23:16] irq[15:8] flag[7:0]
   localparam int NV = 19;
   localparam logic [43:0] VEC [NV] = '{
      {3'd2, 1'b1, 16'h00FE, 8'hFF, 8'h00, 8'h00},  // R4 enable, pins idle
      {3'd0, 1'b0, 16'h0000, 8'hF7, 8'h08, 8'h08},  // R4 level low pin3
      {3'd0, 1'b0, 16'h0000, 8'hFF, 8'h00, 8'h00},  // R4 level released
      {3'd0, 1'b1, 16'h00E4, 8'hFF, 8'h00, 8'h00},  // R3 p1 rise p2 fall p3 any
      {3'd0, 1'b0, 16'h0000, 8'hFD, 8'h00, 8'h00},  // R5 fall on rise-mode pin
      {3'd0, 1'b0, 16'h0000, 8'hFF, 8'h02, 8'h02},  // R5 rise sets p1
      {3'd0, 1'b0, 16'h0000, 8'hFB, 8'h06, 8'h06},  // R5 fall sets p2
      {3'd4, 1'b1, 16'h0002, 8'hFB, 8'h04, 8'h04},  // R6 clear p1
      {3'd0, 1'b0, 16'h0000, 8'hFF, 8'h04, 8'h04},  // R5 rise on fall-mode pin
      {3'd4, 1'b1, 16'h0004, 8'hFF, 8'h00, 8'h00},  // R6 clear p2
      {3'd0, 1'b0, 16'h0000, 8'hF7, 8'h08, 8'h08},  // R5 any-mode fall
      {3'd4, 1'b1, 16'h0000, 8'hF7, 8'h08, 8'h08},  // R6 zero write no effect
      {3'd4, 1'b1, 16'h0008, 8'hF7, 8'h00, 8'h00},  // R6 clear p3
      {3'd0, 1'b0, 16'h0000, 8'hFF, 8'h08, 8'h08},  // R5 any-mode rise
      {3'd1, 1'b1, 16'h0008, 8'hFF, 8'h00, 8'h08},  // R8 output blocks request
      {3'd1, 1'b1, 16'h0000, 8'hFF, 8'h08, 8'h08},  // R8 input again
      {3'd2, 1'b1, 16'h00F6, 8'hFF, 8'h00, 8'h08},  // R8 disable blocks request
      {3'd4, 1'b1, 16'h00FF, 8'hFF, 8'h00, 8'h00},  // R6 clear all
      {3'd2, 1'b1, 16'h00FE, 8'hFF, 8'h00, 8'h00}   // R8 re-enable, nothing pending
   };

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wreg(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic rreg(input logic [2:0] a, output logic [15:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic settle();
      repeat (5) @(negedge clk);
   endtask

   initial begin
      logic [15:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rreg(3'd0, rd); check("R1 mode reset", rd, 16'h0000);
      rreg(3'd1, rd); check("R1 dir reset", rd, 16'h0000);
      rreg(3'd2, rd); check("R1 ena reset", rd, 16'h0000);
      rreg(3'd4, rd); check("R1 flag reset", rd, 16'h0000);
      check("R1 irq reset", {8'h0, irq_req}, 16'h0000);
      check("R1 oe reset", {8'h0, pin_oe}, 16'h0000);

      // table walk
      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         pin_in    = VEC[v][23:16];
         reg_addr  = VEC[v][43:41];
         reg_wr    = VEC[v][40];
         reg_wdata = VEC[v][39:24];
         @(negedge clk);
         reg_wr = 1'b0;
         settle();
         rreg(3'd4, rd);
         check($sformatf("R5/R6/R8 vec%0d irq", v), {8'h0, irq_req}, {8'h0, VEC[v][15:8]});
         check($sformatf("R4/R5/R6 vec%0d flag", v), rd, {8'h0, VEC[v][7:0]});
      end
      rreg(3'd0, rd); check("R3 mode readback", rd, 16'h00E4);

      // R7 edge and clear in the same cycle
      wreg(3'd0, 16'h0004);
      wreg(3'd2, 16'h0002);
      @(negedge clk); pin_in = 8'hFD; settle();
      @(negedge clk); pin_in = 8'hFF; settle();
      rreg(3'd4, rd); check("R7 pre flag", rd, 16'h0002);
      @(negedge clk); pin_in = 8'hFD; settle();
      @(negedge clk); pin_in = 8'hFF;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      reg_addr = 3'd4; reg_wdata = 16'h0002; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
      rreg(3'd4, rd); check("R7 edge beats clear flag", rd, 16'h0002);
      check("R7 edge beats clear irq", {8'h0, irq_req}, 16'h0002);
      wreg(3'd4, 16'h0002);
      rreg(3'd4, rd); check("R6 plain clear", rd, 16'h0000);

      // R10 latency, level mode on pin1
      wreg(3'd0, 16'h0000);
      settle();
      @(negedge clk); pin_in = 8'hFD;
      @(negedge clk); check("R10 after 1 edge", {8'h0, irq_req}, 16'h0000);
      @(negedge clk); check("R10 after 2 edges", {8'h0, irq_req}, 16'h0000);
      @(negedge clk); check("R10 after 3 edges", {8'h0, irq_req}, 16'h0002);
      @(negedge clk); pin_in = 8'hFF; settle();
      check("R4 released", {8'h0, irq_req}, 16'h0000);

      // R2 reserved position
      wreg(3'd0, 16'h0003);
      wreg(3'd2, 16'h00FF);
      wreg(3'd1, 16'h0001);
      wreg(3'd3, 16'h0001);
      @(negedge clk); pin_in = 8'hFE; settle();
      @(negedge clk); pin_in = 8'hFF; settle();
      rreg(3'd0, rd); check("R2 mode bit0", rd, 16'h0000);
      rreg(3'd2, rd); check("R2 ena bit0", rd, 16'h00FE);
      rreg(3'd1, rd); check("R2 dir bit0", rd, 16'h0000);
      rreg(3'd4, rd); check("R2 flag bit0", rd, 16'h0000);
      check("R2 irq/oe/out bit0", {5'h0, irq_req[0], pin_oe[0], pin_out[0]}, 16'h0000);

      // R9 outputs and data read, with R4/R8 on the input pins
      wreg(3'd3, 16'h00A6);
      wreg(3'd1, 16'h00F0);
      @(negedge clk); pin_in = 8'hF5; settle();
      check("R9 pin_oe", {8'h0, pin_oe}, 16'h00F0);
      check("R9 pin_out", {8'h0, pin_out}, 16'h00A6);
      rreg(3'd3, rd); check("R9 data read", rd, 16'h00A4);
      check("R8 level inputs only", {8'h0, irq_req}, 16'h000A);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

endmodule